// File: doc/BRIEF.md
# Byte Alignment Shifter

This datapath joins two 16-byte vectors into a 32-byte window and extracts a 16-byte slice from it. The upper vector fills the top half of the window and the lower vector fills the bottom half. The slice starts at a byte offset given by an 8-bit shift operand, so the result is the window shifted right by that many bytes, truncated to 16 bytes. It is typically used to splice unaligned data that straddles two naturally aligned vector loads.

Every shift value from 0 to 255 has a defined result. Offsets that reach past the lower vector take bytes from the upper vector and fill with zero bytes from above. Offsets of 32 or more produce an all-zero result. The input is accepted under a valid strobe. The result and its own valid strobe are registered, so they appear one clock later.

Top module: `align_shifter`

## Requirements
- R1: Byte j of a vector occupies bits [8j+7:8j]. Window byte k is lo byte k for k < 16 and hi byte k-16 for 16 <= k < 32. Result byte i equals window byte i+N when i+N < 32, and is zero otherwise (N is the shift value).
- R2: A shift of 0 returns the lower vector unchanged.
- R3: A shift of 16 returns the upper vector unchanged.
- R4: A shift N from 17 to 32 returns the upper vector shifted right by N-16 bytes, with zero bytes filling the top N-16 byte positions.
- R5: Any shift greater than 32, up to 255, gives an all-zero result.
- R6: A shift of 15 gives result byte 0 equal to lo byte 15, and result bytes 1 to 15 equal to hi bytes 0 to 14.
- R7: out_valid is high exactly one cycle after a cycle with in_valid high, and out_data in that cycle holds the result for the inputs captured with it.
- R8: A synchronous reset drives out_valid low and out_data to zero at the next clock edge, even when in_valid is high.
- R9: While in_valid is low, the inputs are ignored. out_valid is low one cycle later and out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operands in this cycle |
| in_hi | input | 128 | Vector forming the upper half of the window |
| in_lo | input | 128 | Vector forming the lower half of the window |
| in_shift | input | 8 | Unsigned right-shift amount in bytes |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 128 | Aligned 16-byte result |

## Verification
Every result, including the all-zero result for large shifts, is due at the first rising edge after the edge that captures the operands. Reset takes effect at the next edge, and the held value during idle cycles is also updated at an edge. The bench drives operands on the falling edge and reads out_valid and out_data on the following falling edge, half a period after the capturing edge. It never reads the outputs at the edge itself. Idle-cycle and reset checks use the same falling-edge sampling, one edge after the stimulus is applied.

// File: rtl/align_pkg.sv
package align_pkg;

    // Width of one vector element in bits.
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned DEF_LANES     = 16;
    localparam int unsigned DEF_SHIFT_W   = 8;

    // Classification of a shift amount against the joined window.
    typedef enum logic [1:0] {
        REG_BASE  = 2'd0,   // shift of zero: lower vector passes through
        REG_MIX   = 2'd1,   // 1..LANES: bytes drawn from both vectors
        REG_UPPER = 2'd2,   // LANES+1..2*LANES-1: upper vector, zero fill
        REG_EMPTY = 2'd3    // 2*LANES and above: nothing left in window
    } region_t;

endpackage

// File: rtl/align_count_decode.sv
module align_count_decode
    import align_pkg::*;
#(
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned SHIFT_W = DEF_SHIFT_W,
    parameter int unsigned IDX_W   = $clog2(2 * LANES) + 1
) (
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [IDX_W-1:0]   idx_o,
    output region_t            region_o
);

    localparam int unsigned WIN = 2 * LANES;

    // Saturate the shift to the window size so the lane pickers work on a
    // narrow index, independent of how wide the shift operand is.
    always_comb begin
        if (int'(shift_i) >= int'(WIN)) begin
            idx_o    = IDX_W'(WIN);
            region_o = REG_EMPTY;
        end else begin
            idx_o = IDX_W'(shift_i);
            if (int'(shift_i) == 0) begin
                region_o = REG_BASE;
            end else if (int'(shift_i) <= int'(LANES)) begin
                region_o = REG_MIX;
            end else begin
                region_o = REG_UPPER;
            end
        end
    end

endmodule

// File: rtl/align_byte_pick.sv
module align_byte_pick
    import align_pkg::*;
#(
    parameter int unsigned LANE  = 0,
    parameter int unsigned WIN   = 2 * DEF_LANES,
    parameter int unsigned IDX_W = $clog2(WIN) + 1
) (
    input  logic [WIN*BYTE_W-1:0] window_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [BYTE_W-1:0]     byte_o
);

    localparam int unsigned POS_W = IDX_W + 1;

    logic [POS_W-1:0] pos;

    // Output lane LANE takes window byte LANE+idx; past the window it is zero.
    always_comb begin
        pos = POS_W'(LANE) + POS_W'(idx_i);
        if (int'(pos) < int'(WIN)) begin
            byte_o = window_i[int'(pos)*BYTE_W +: BYTE_W];
        end else begin
            byte_o = '0;
        end
    end

endmodule

// File: rtl/align_shifter.sv
module align_shifter
    import align_pkg::*;
#(
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned SHIFT_W = DEF_SHIFT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*BYTE_W-1:0]   in_hi,
    input  logic [LANES*BYTE_W-1:0]   in_lo,
    input  logic [SHIFT_W-1:0]        in_shift,
    output logic                      out_valid,
    output logic [LANES*BYTE_W-1:0]   out_data
);

    localparam int unsigned VEC_W = LANES * BYTE_W;
    localparam int unsigned WIN   = 2 * LANES;
    localparam int unsigned IDX_W = $clog2(WIN) + 1;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic [2*VEC_W-1:0] window;
    logic [IDX_W-1:0]   sel_idx;
    region_t            region;
    logic [VEC_W-1:0]   picked;

    assign window = {in_hi, in_lo};

    align_count_decode #(
        .LANES   (LANES),
        .SHIFT_W (SHIFT_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .shift_i  (in_shift),
        .idx_o    (sel_idx),
        .region_o (region)
    );

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        align_byte_pick #(
            .LANE  (g),
            .WIN   (WIN),
            .IDX_W (IDX_W)
        ) u_pick (
            .window_i (window),
            .idx_i    (sel_idx),
            .byte_o   (picked[g*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = (region == REG_EMPTY) ? '0 : picked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data))); // R9
    AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shift == '0) |=> (out_data == $past(in_lo))); // R2
    AST_HALF_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(in_shift) == int'(LANES)) |=> (out_data == $past(in_hi))); // R3
    AST_FAR_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(in_shift) > int'(WIN)) |=> (out_data == '0)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R8

endmodule

// File: tb/align_shifter_bench.sv
module align_shifter_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_hi;
    logic [127:0] in_lo;
    logic [7:0]   in_shift;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    align_shifter u_align_shifter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_hi     (in_hi),
        .in_lo     (in_lo),
        .in_shift  (in_shift),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [127:0] model(logic [127:0] hi, logic [127:0] lo, int sh);
        logic [255:0] w;
        w = {hi, lo};
        if (sh >= 32) return '0;
        w = w >> (sh * 8);
        return w[127:0];
    endfunction

    function automatic string tag_of(int sh);
        if (sh == 0)  return "R2";
        if (sh == 15) return "R6";
        if (sh == 16) return "R3";
        if (sh > 32)  return "R5";
        if (sh > 16)  return "R4";
        return "R1";
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operand set, check the registered result one cycle later.
    task automatic push(logic [127:0] hi, logic [127:0] lo, int sh, logic [127:0] exp, string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_hi    = hi;
        in_lo    = lo;
        in_shift = 8'(sh);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", 128'(out_valid), 128'd1);
        chk(out_data == exp, req, out_data, exp);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [127:0] hi, lo, held;
        void'($urandom(32'h1A2B3C4D));
        rst = 1'b1; in_valid = 1'b0; in_hi = '0; in_lo = '0; in_shift = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", 128'(out_valid), 128'd0);
        chk(out_data == '0, "R8", out_data, '0);
        rst = 1'b0;

        // Directed patterns: lo byte j = 0xA0+j, hi byte j = 0x10+j.
        for (int j = 0; j < 16; j++) begin
            lo[j*8 +: 8] = 8'(8'hA0 + j);
            hi[j*8 +: 8] = 8'(8'h10 + j);
        end
        push(hi, lo, 0,   lo,                          "R2");
        push(hi, lo, 16,  hi,                          "R3");
        push(hi, lo, 15,  {hi[119:0], lo[127:120]},    "R6");
        push(hi, lo, 20,  {32'h0, hi[127:32]},         "R4");
        push(hi, lo, 32,  '0,                          "R4");
        push(hi, lo, 33,  '0,                          "R5");
        push(hi, lo, 255, '0,                          "R5");
        push(hi, lo, 5,   {hi[39:0], lo[127:40]},      "R1");

        // Sweep every shift value with random vectors, twice.
        for (int rep = 0; rep < 2; rep++) begin
            for (int s = 0; s < 256; s++) begin
                hi = rnd128();
                lo = rnd128();
                push(hi, lo, s, model(hi, lo, s), tag_of(s));
            end
        end

        // Random shift values, back-to-back valid cycles.
        for (int n = 0; n < 200; n++) begin
            int s;
            hi = rnd128();
            lo = rnd128();
            s  = int'($urandom_range(0, 255));
            @(negedge clk);
            in_valid = 1'b1; in_hi = hi; in_lo = lo; in_shift = 8'(s);
            @(negedge clk);
            chk(out_valid == 1'b1, "R7", 128'(out_valid), 128'd1);
            chk(out_data == model(hi, lo, s), tag_of(s), out_data, model(hi, lo, s));
        end
        in_valid = 1'b0;

        // R9: idle cycles with changing operands must leave the output alone.
        push(hi, lo, 3, model(hi, lo, 3), "R1");
        held = out_data;
        for (int n = 0; n < 4; n++) begin
            in_hi = rnd128(); in_lo = rnd128(); in_shift = 8'($urandom_range(0, 255));
            @(negedge clk);
            chk(out_valid == 1'b0, "R9", 128'(out_valid), 128'd0);
            chk(out_data == held, "R9", out_data, held);
        end

        // R8: reset wins over a valid input in the same cycle.
        push(hi, lo, 0, lo, "R2");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_shift = 8'd0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", 128'(out_valid), 128'd0);
        chk(out_data == '0, "R8", out_data, '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule